// File: doc/BRIEF.md
# Two-Port Collision-Aware RAM

This block is a synchronous random-access memory with two independent access ports, A and B. Each port has its own enable, write-enable, address, write data and read data. Two agents, such as a processor and a transfer engine, can therefore use the storage in the same clock cycle. Accesses to different locations never interfere with each other. Two reads of one location in the same cycle both return the stored word.

When both ports touch the same location in one cycle and at least one of them writes, the block applies a fixed rule and does not leave the result undefined. Port A has priority over port B when both write. A port that reads while the other port writes gets the word held before that write. For one cycle after such an event, a per-port collision flag marks the port whose access was disturbed.

Read data and collision flags are registered. They appear on the clock edge that accepts the request. The depth and the word width are parameters, and the storage array is not cleared by reset.

Top module: `dpram_cd`

## Requirements
- R1: After reset, both read-data outputs are zero and both collision flags are low.
- R2: A word written through either port is returned by a later read of the same address on either port, one clock edge after the read request.
- R3: Accesses on the two ports to different addresses in the same cycle complete independently and raise no collision flag.
- R4: Two reads of the same address in the same cycle both return the stored word, and neither collision flag is raised.
- R5: When both ports write the same address in the same cycle, port A's data is stored and port B's data is dropped. For the cycle after that request, `b_clash` is 1 and `a_clash` is 0.
- R6: When one port reads an address that the other port writes in the same cycle, the reader gets the word from before the write, and the write takes effect. For the cycle after that request, only the reader's collision flag is 1.
- R7: A port whose enable is low neither reads nor writes and causes no collision on either port.
- R8: A port's read data holds its previous value on any cycle in which that port does not issue a read (disabled, or writing).
- R9: A collision flag stays high for one cycle only. It is low after any request cycle that has no collision for that port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | $clog2(DEPTH) | Port A address |
| a_wdata | input | WIDTH | Port A write data |
| a_rdata | output | WIDTH | Port A registered read data |
| a_clash | output | 1 | Port A collision flag, one cycle |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | $clog2(DEPTH) | Port B address |
| b_wdata | input | WIDTH | Port B write data |
| b_rdata | output | WIDTH | Port B registered read data |
| b_clash | output | 1 | Port B collision flag, one cycle |

## Verification
Every result of this block is due at exactly one rising edge after the request: the read word, the held read word and both collision flags. A write becomes visible to reads issued from the next cycle on. The bench drives each request on a falling edge and compares all four outputs at the next falling edge. The reference model is updated only after that comparison, which keeps the read-before-write rule of R6 intact. The sweep covers every pairing of idle, read and write across all address pairs of an 8-word memory, so every same-address and different-address case is visited.

// File: rtl/dpram_cd_pkg.sv
package dpram_cd_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  function automatic acc_e acc_kind(input logic en, input logic we);
    if (!en)     return ACC_IDLE;
    else if (we) return ACC_WRITE;
    else         return ACC_READ;
  endfunction

  // port x is disturbed when the other port writes the same location
  // and x itself is active; for the write-write case only port B loses
  function automatic logic is_disturbed(input acc_e self_k, input acc_e other_k,
                                        input logic same_loc, input logic self_has_prio);
    if (!same_loc || other_k != ACC_WRITE || self_k == ACC_IDLE) return 1'b0;
    if (self_k == ACC_WRITE && self_has_prio)                    return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/dpram_cd_arb.sv
module dpram_cd_arb
  import dpram_cd_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  output logic          a_wr_go,
  output logic          b_wr_go,
  output logic          a_hit,
  output logic          b_hit,
  output logic          a_clash,
  output logic          b_clash
);

  acc_e a_k, b_k;
  logic same_loc;

  always_comb begin
    a_k      = acc_kind(a_en, a_we);
    b_k      = acc_kind(b_en, b_we);
    same_loc = (a_addr == b_addr);
    a_hit    = is_disturbed(a_k, b_k, same_loc, 1'b1);
    b_hit    = is_disturbed(b_k, a_k, same_loc, 1'b0);
    a_wr_go  = (a_k == ACC_WRITE);
    b_wr_go  = (b_k == ACC_WRITE) && !(same_loc && a_k == ACC_WRITE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_clash <= 1'b0;
      b_clash <= 1'b0;
    end else begin
      a_clash <= a_hit;
      b_clash <= b_hit;
    end
  end

endmodule

// File: rtl/dpram_cd_store.sv
module dpram_cd_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  parameter int NP    = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NP-1:0]             wr_go,
  input  logic [NP-1:0]             rd_go,
  input  logic [NP-1:0][AW-1:0]     addr,
  input  logic [NP-1:0][WIDTH-1:0]  wdata,
  output logic [NP-1:0][WIDTH-1:0]  rdata
);

  logic [WIDTH-1:0] cells [DEPTH];

  // writes never target the same cell here: the arbiter drops the loser
  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (wr_go[p]) cells[addr[p]] <= wdata[p];
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_rd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rdata[p] <= '0;
      else if (rd_go[p]) rdata[p] <= cells[addr[p]];
    end
  end

endmodule

// File: rtl/dpram_cd.sv
module dpram_cd #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_en,
  input  logic             a_we,
  input  logic [AW-1:0]    a_addr,
  input  logic [WIDTH-1:0] a_wdata,
  output logic [WIDTH-1:0] a_rdata,
  output logic             a_clash,
  input  logic             b_en,
  input  logic             b_we,
  input  logic [AW-1:0]    b_addr,
  input  logic [WIDTH-1:0] b_wdata,
  output logic [WIDTH-1:0] b_rdata,
  output logic             b_clash
);

  logic a_wr_go, b_wr_go, a_hit, b_hit;
  logic [1:0]            rd_go;
  logic [1:0][AW-1:0]    addr_v;
  logic [1:0][WIDTH-1:0] wdata_v, rdata_v;

  dpram_cd_arb #(.AW(AW)) arb_i (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
    .a_wr_go(a_wr_go), .b_wr_go(b_wr_go),
    .a_hit(a_hit), .b_hit(b_hit),
    .a_clash(a_clash), .b_clash(b_clash)
  );

  assign rd_go   = {b_en && !b_we, a_en && !a_we};
  assign addr_v  = {b_addr, a_addr};
  assign wdata_v = {b_wdata, a_wdata};

  dpram_cd_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .NP(2)) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_go({b_wr_go, a_wr_go}),
    .rd_go(rd_go),
    .addr(addr_v),
    .wdata(wdata_v),
    .rdata(rdata_v)
  );

  assign a_rdata = rdata_v[0];
  assign b_rdata = rdata_v[1];

endmodule

// File: rtl/dpram_cd_chk.sv
module dpram_cd_chk #(
  parameter int AW    = 3,
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             a_en,
  input logic             a_we,
  input logic [AW-1:0]    a_addr,
  input logic [WIDTH-1:0] a_rdata,
  input logic             a_clash,
  input logic             b_en,
  input logic             b_we,
  input logic [AW-1:0]    b_addr,
  input logic [WIDTH-1:0] b_rdata,
  input logic             b_clash,
  input logic             a_wr_go,
  input logic             b_wr_go
);

  a_r5_ww_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && a_we && b_en && b_we && a_addr == b_addr) |=> (b_clash && !a_clash));

  a_r5_drop_b: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && a_we && b_en && b_we && a_addr == b_addr) |-> (a_wr_go && !b_wr_go));

  a_r6_a_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && !a_we && b_en && b_we && a_addr == b_addr) |=> (a_clash && !b_clash));

  a_r6_b_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && !b_we && a_en && a_we && a_addr == b_addr) |=> (b_clash && !a_clash));

  a_r4_rr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && !a_we && b_en && !b_we) |=> (!a_clash && !b_clash));

  a_r7_a_off: assert property (@(posedge clk) disable iff (!rst_n)
    !a_en |=> (!a_clash && !b_clash));

  a_r7_b_off: assert property (@(posedge clk) disable iff (!rst_n)
    !b_en |=> (!a_clash && !b_clash));

  a_r3_apart: assert property (@(posedge clk) disable iff (!rst_n)
    (a_addr != b_addr) |=> (!a_clash && !b_clash));

  a_r8_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_en && !a_we) |=> $stable(a_rdata));

  a_r8_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_en && !b_we) |=> $stable(b_rdata));

endmodule

bind dpram_cd dpram_cd_chk #(.AW(AW), .WIDTH(WIDTH)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_rdata(a_rdata), .a_clash(a_clash),
  .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_rdata(b_rdata), .b_clash(b_clash),
  .a_wr_go(a_wr_go), .b_wr_go(b_wr_go)
);

// File: tb/dpram_cd_tb.sv
module dpram_cd_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int WIDTH = 8;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_en = 0, a_we = 0, b_en = 0, b_we = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [WIDTH-1:0] a_wdata = '0, b_wdata = '0;
  logic [WIDTH-1:0] a_rdata, b_rdata;
  logic a_clash, b_clash;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [WIDTH-1:0] model [DEPTH];
  logic [WIDTH-1:0] ra_prev = '0, rb_prev = '0;
  logic ca_prev = 0, cb_prev = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dpram_cd #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_clash(a_clash),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_clash(b_clash)
  );

  task automatic check(input string tag, input string what,
                       input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // op: 0 idle, 1 read, 2 write
  task automatic step(input int ao, input int aa, input logic [WIDTH-1:0] da,
                      input int bo, input int ba, input logic [WIDTH-1:0] db);
    logic [WIDTH-1:0] ea, eb;
    logic eca, ecb, same;
    string ta, tb, tfa, tfb;
    a_en = (ao != 0); a_we = (ao == 2); a_addr = AW'(aa); a_wdata = da;
    b_en = (bo != 0); b_we = (bo == 2); b_addr = AW'(ba); b_wdata = db;
    same = (aa == ba);
    ea  = (ao == 1) ? model[aa] : ra_prev;          // R6 old data, R8 hold
    eb  = (bo == 1) ? model[ba] : rb_prev;
    eca = (ao == 1) && (bo == 2) && same;           // R6
    ecb = (bo != 0) && (ao == 2) && same;           // R5 / R6
    ta = (ao == 0) ? "R7" : (ao == 2) ? "R8" : (eca ? "R6" : (bo == 1 && same) ? "R4" : (same ? "R2" : "R3"));
    tb = (bo == 0) ? "R7" : (bo == 2) ? "R8" : (ecb ? "R6" : (ao == 1 && same) ? "R4" : (same ? "R2" : "R3"));
    tfa = eca ? "R6" : ca_prev ? "R9" : (ao == 0 || bo == 0) ? "R7" : same ? "R4" : "R3";
    tfb = ecb ? ((bo == 2) ? "R5" : "R6") : cb_prev ? "R9" : (ao == 0 || bo == 0) ? "R7" : same ? "R4" : "R3";
    @(posedge clk);
    @(negedge clk);
    check(ta,  "a_rdata", a_rdata, ea);
    check(tb,  "b_rdata", b_rdata, eb);
    check(tfa, "a_clash", WIDTH'(a_clash), WIDTH'(eca));
    check(tfb, "b_clash", WIDTH'(b_clash), WIDTH'(ecb));
    if (bo == 2 && !(ao == 2 && same)) model[ba] = db;   // R5 B dropped on tie
    if (ao == 2) model[aa] = da;
    ra_prev = ea; rb_prev = eb; ca_prev = eca; cb_prev = ecb;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "a_rdata", a_rdata, '0);
    check("R1", "b_rdata", b_rdata, '0);
    check("R1", "a_clash", WIDTH'(a_clash), '0);
    check("R1", "b_clash", WIDTH'(b_clash), '0);
    rst_n = 1'b1;
    @(negedge clk);
    // fill: A writes even cells, B writes odd cells (R3, R2)
    for (int i = 0; i < DEPTH; i += 2)
      step(2, i, WIDTH'(8'h10 + i), 2, i + 1, WIDTH'(8'h20 + i));
    for (int i = 0; i < DEPTH; i++) step(1, i, '0, 1, DEPTH - 1 - i, '0);
    // exhaustive sweep of op pairs over all address pairs
    for (int ao = 0; ao < 3; ao++)
      for (int bo = 0; bo < 3; bo++)
        for (int aa = 0; aa < DEPTH; aa++)
          for (int ba = 0; ba < DEPTH; ba++) begin
            step(ao, aa, WIDTH'(ao * 61 + aa * 13 + ba * 7 + 1),
                 bo, ba, WIDTH'(bo * 29 + aa * 5 + ba * 17 + 3));
            if (ba == aa) step(0, 0, '0, 0, 0, '0);   // R9 flags drop
          end
    // read-back of everything on both ports (R2)
    for (int i = 0; i < DEPTH; i++) step(1, i, '0, 1, i, '0);
    finish_run();
  end

endmodule